// File: doc/BRIEF.md
# Fault Escalation and Delivery Sequencer

This block sits beside the control path of a processor core and takes over each exception request the core raises. It keeps a count of faults that are still nested, meaning raised but not yet delivered. From that count it decides the outcome of each request:

- It passes the request's own vector through.
- It replaces the vector with the double-fault vector (8).
- Once the count reaches three, it stops and asks for a core reset.

When a request goes on to delivery, the sequencer first strobes the core so that the instruction pointer and the stack pointer go back to their values from the start of the faulting instruction. The same strobe clears the pending prefix flags. The sequencer then starts two handshakes in turn. The first asks the descriptor-table logic to fetch the vector entry. The second asks the stack logic to push the frame.

The block decides whether an error code goes into the frame. The code is pushed only for vectors that carry one, and only while protection is enabled. A failed fetch or push sends the sequencer back to idle with the nesting count untouched. The fault that the core raises next is therefore escalated. A successful push sets the count back to zero. While a request is in progress, the `busy` output blocks new requests.

Top module: `exc_escalator`

## Requirements
- R1: A request is taken when `req_valid` is high while `busy` is low. From the next cycle, `busy` stays high until the sequence ends.
- R2: Each accepted request adds one to the nesting depth. A request that raises the depth only to 1 keeps its own vector on `out_vector`.
- R3: When an accepted request raises the depth above 1 but below 3, `out_vector` becomes the double-fault vector 8.
- R4: When an accepted request raises the depth to 3:
  - `core_reset` is high for exactly the following cycle.
  - The depth is cleared.
  - No restore strobe, fetch or delivery follows.
  - `busy` is low again one cycle later.
- R5: `restore_ip`, `restore_sp` and `clear_prefix` are high together for exactly one cycle, the cycle right after acceptance. `fetch_req` rises in the cycle after that.
- R6: `fetch_req` stays high until `fetch_done`. If `fetch_ok` is low at `fetch_done`, the sequencer returns to idle, never raises `deliver_req`, and keeps the depth.
- R7: After a good fetch, `deliver_req` stays high until `deliver_done`. If `deliver_ok` is low at that point, the sequencer returns to idle and keeps the depth.
- R8: A delivery with `deliver_ok` high clears the depth to 0, so the next request keeps its own vector.
- R9: `push_errcode` is high only when both of these hold:
  - `prot_en` was high at acceptance.
  - The final vector is one of 8, 10, 11, 12, 13, 14 or 17.

  `out_errcode` holds the `req_errcode` sampled at acceptance.
- R10: A request presented while `busy` is high is ignored. This includes the cycle in which `deliver_done` arrives.
- R11: After reset, `busy`, all strobes, `core_reset` and `push_errcode` are low, and the depth is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request |
| req_vector | input | VEC_W | Raw exception vector |
| req_errcode | input | ERR_W | Error code of the request |
| prot_en | input | 1 | Protection enabled |
| fetch_done | input | 1 | Vector-entry fetch finished |
| fetch_ok | input | 1 | Fetch succeeded (valid with fetch_done) |
| deliver_done | input | 1 | Frame push finished |
| deliver_ok | input | 1 | Push succeeded (valid with deliver_done) |
| busy | output | 1 | Sequence in progress, requests blocked |
| out_vector | output | VEC_W | Final vector after escalation |
| out_errcode | output | ERR_W | Latched error code |
| push_errcode | output | 1 | Frame carries the error code |
| restore_ip | output | 1 | Restore instruction pointer strobe |
| restore_sp | output | 1 | Restore stack pointer strobe |
| clear_prefix | output | 1 | Clear prefix flags strobe |
| fetch_req | output | 1 | Request vector-entry fetch |
| deliver_req | output | 1 | Request frame delivery |
| core_reset | output | 1 | One-cycle core reset request |

## Verification
Two events can land in the same clock edge: a delivery succeeding and clearing the depth, and a new request arriving. The bench holds `req_valid` high, with a fresh vector, in the very cycle that `deliver_done` and `deliver_ok` are driven. It then checks that `busy` drops without that request being taken. A following request must come out with its own vector, which shows both that the clear happened and that the colliding request left no trace in the depth. A second collision is a request whose increment reaches the reset depth. There, the bench confirms that the clear wins over the increment, so the next fault starts again from depth 1.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RESTORE = 3'd1,
    ST_FETCH   = 3'd2,
    ST_DELIVER = 3'd3,
    ST_RESET   = 3'd4
  } seq_state_t;

  // Vectors whose frame carries an error code.
  function automatic logic carries_errcode(input logic [31:0] vec);
    case (vec)
      32'd8, 32'd10, 32'd11, 32'd12, 32'd13, 32'd14, 32'd17: carries_errcode = 1'b1;
      default: carries_errcode = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/exc_nest_counter.sv
module exc_nest_counter #(
  parameter int LIMIT = 3,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] depth,
  output logic [CW-1:0] depth_inc
);

  assign depth_inc = depth + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)   depth <= '0;
    else if (clr) depth <= '0;
    else if (inc) depth <= depth_inc;
  end

endmodule

// File: rtl/exc_vector_select.sv
module exc_vector_select #(
  parameter int VEC_W     = 8,
  parameter int DF_VECTOR = 8,
  parameter int CW        = 2
) (
  input  logic [VEC_W-1:0] req_vector,
  input  logic [CW-1:0]    depth_inc,
  input  logic             prot_en,
  output logic             escalate,
  output logic [VEC_W-1:0] final_vector,
  output logic             push_flag
);

  assign escalate     = (depth_inc > CW'(1));
  assign final_vector = escalate ? VEC_W'(DF_VECTOR) : req_vector;
  assign push_flag    = prot_en && exc_seq_pkg::carries_errcode(32'(final_vector));

endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       triple_hit,
  input  logic       fetch_done,
  input  logic       fetch_ok,
  input  logic       deliver_done,
  input  logic       deliver_ok,
  output seq_state_t state,
  output logic       accept,
  output logic       deliver_success,
  output logic       flow_abort
);

  seq_state_t state_nx;

  assign accept          = (state == ST_IDLE) && req_valid;
  assign deliver_success = (state == ST_DELIVER) && deliver_done && deliver_ok;
  assign flow_abort      = ((state == ST_FETCH) && fetch_done && !fetch_ok) ||
                           ((state == ST_DELIVER) && deliver_done && !deliver_ok);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:    if (accept) state_nx = triple_hit ? ST_RESET : ST_RESTORE;
      ST_RESTORE: state_nx = ST_FETCH;
      ST_FETCH:   if (fetch_done) state_nx = fetch_ok ? ST_DELIVER : ST_IDLE;
      ST_DELIVER: if (deliver_done) state_nx = ST_IDLE;
      ST_RESET:   state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/exc_escalator.sv
module exc_escalator
  import exc_seq_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int ERR_W     = 32,
  parameter int DF_VECTOR = 8,
  parameter int LIMIT     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vector,
  input  logic [ERR_W-1:0] req_errcode,
  input  logic             prot_en,
  input  logic             fetch_done,
  input  logic             fetch_ok,
  input  logic             deliver_done,
  input  logic             deliver_ok,
  output logic             busy,
  output logic [VEC_W-1:0] out_vector,
  output logic [ERR_W-1:0] out_errcode,
  output logic             push_errcode,
  output logic             restore_ip,
  output logic             restore_sp,
  output logic             clear_prefix,
  output logic             fetch_req,
  output logic             deliver_req,
  output logic             core_reset
);

  localparam int CW = $clog2(LIMIT + 1);

  seq_state_t       state;
  logic             accept_w;
  logic             deliver_success;
  logic             flow_abort;
  logic             triple_hit;
  logic             escalate;
  logic [CW-1:0]    depth_q;
  logic [CW-1:0]    depth_inc;
  logic [VEC_W-1:0] final_vector;
  logic             push_flag;

  assign triple_hit = (depth_inc == CW'(LIMIT));

  exc_nest_counter #(.LIMIT(LIMIT)) u_depth (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (accept_w),
    .clr       ((accept_w && triple_hit) || deliver_success),
    .depth     (depth_q),
    .depth_inc (depth_inc)
  );

  exc_vector_select #(.VEC_W(VEC_W), .DF_VECTOR(DF_VECTOR), .CW(CW)) u_vsel (
    .req_vector   (req_vector),
    .depth_inc    (depth_inc),
    .prot_en      (prot_en),
    .escalate     (escalate),
    .final_vector (final_vector),
    .push_flag    (push_flag)
  );

  exc_seq_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .triple_hit      (triple_hit),
    .fetch_done      (fetch_done),
    .fetch_ok        (fetch_ok),
    .deliver_done    (deliver_done),
    .deliver_ok      (deliver_ok),
    .state           (state),
    .accept          (accept_w),
    .deliver_success (deliver_success),
    .flow_abort      (flow_abort)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vector   <= '0;
      out_errcode  <= '0;
      push_errcode <= 1'b0;
    end else if (accept_w) begin
      out_vector   <= final_vector;
      out_errcode  <= req_errcode;
      push_errcode <= push_flag && !triple_hit;
    end
  end

  assign busy         = (state != ST_IDLE);
  assign restore_ip   = (state == ST_RESTORE);
  assign restore_sp   = (state == ST_RESTORE);
  assign clear_prefix = (state == ST_RESTORE);
  assign fetch_req    = (state == ST_FETCH);
  assign deliver_req  = (state == ST_DELIVER);
  assign core_reset   = (state == ST_RESET);

endmodule

// File: rtl/exc_escalator_chk.sv
module exc_escalator_chk #(
  parameter int VEC_W     = 8,
  parameter int DF_VECTOR = 8,
  parameter int CW        = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept_w,
  input logic             triple_hit,
  input logic             escalate,
  input logic             deliver_success,
  input logic             flow_abort,
  input logic [CW-1:0]    depth_q,
  input logic             busy,
  input logic [VEC_W-1:0] out_vector,
  input logic             push_errcode,
  input logic             restore_ip,
  input logic             fetch_req,
  input logic             core_reset
);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> busy); // R1
  AST_DF_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && escalate && !triple_hit) |=> (out_vector == VEC_W'(DF_VECTOR))); // R3
  AST_TRIPLE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && triple_hit) |=> (core_reset && depth_q == '0)); // R4
  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> (!core_reset && !busy)); // R4
  AST_RESTORE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    restore_ip |=> (fetch_req && !restore_ip)); // R5
  AST_ABORT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    flow_abort |=> $stable(depth_q)); // R6
  AST_CLEAR_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_success |=> (depth_q == '0)); // R8
  AST_PUSH_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    push_errcode |-> exc_seq_pkg::carries_errcode(32'(out_vector))); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept_w); // R10

endmodule

bind exc_escalator exc_escalator_chk #(.VEC_W(VEC_W), .DF_VECTOR(DF_VECTOR), .CW(CW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .accept_w        (accept_w),
  .triple_hit      (triple_hit),
  .escalate        (escalate),
  .deliver_success (deliver_success),
  .flow_abort      (flow_abort),
  .depth_q         (depth_q),
  .busy            (busy),
  .out_vector      (out_vector),
  .push_errcode    (push_errcode),
  .restore_ip      (restore_ip),
  .fetch_req       (fetch_req),
  .core_reset      (core_reset)
);

// File: tb/exc_escalator_bench.sv
module exc_escalator_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vector = '0;
  logic [31:0] req_errcode = '0;
  logic        prot_en = 1'b0;
  logic        fetch_done = 1'b0, fetch_ok = 1'b0;
  logic        deliver_done = 1'b0, deliver_ok = 1'b0;
  logic        busy, push_errcode, restore_ip, restore_sp, clear_prefix;
  logic        fetch_req, deliver_req, core_reset;
  logic [7:0]  out_vector;
  logic [31:0] out_errcode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  exc_escalator u_exc_escalator (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .req_errcode(req_errcode), .prot_en(prot_en), .fetch_done(fetch_done),
    .fetch_ok(fetch_ok), .deliver_done(deliver_done), .deliver_ok(deliver_ok),
    .busy(busy), .out_vector(out_vector), .out_errcode(out_errcode),
    .push_errcode(push_errcode), .restore_ip(restore_ip), .restore_sp(restore_sp),
    .clear_prefix(clear_prefix), .fetch_req(fetch_req), .deliver_req(deliver_req),
    .core_reset(core_reset)
  );

  typedef struct packed {
    logic [7:0] vec;
    logic       prot;
    logic       fok;
    logic       dok;
    logic [7:0] exp_vec;
    logic       exp_push;
    logic       exp_rst;
  } row_t;

  // Depth before each row follows from earlier rows' fetch/deliver results.
  localparam row_t TBL [17] = '{
    '{8'd14, 1'b1, 1'b1, 1'b1, 8'd14, 1'b1, 1'b0},
    '{8'd3,  1'b1, 1'b1, 1'b1, 8'd3,  1'b0, 1'b0},
    '{8'd13, 1'b0, 1'b1, 1'b1, 8'd13, 1'b0, 1'b0},
    '{8'd17, 1'b1, 1'b1, 1'b1, 8'd17, 1'b1, 1'b0},
    '{8'd9,  1'b1, 1'b1, 1'b1, 8'd9,  1'b0, 1'b0},
    '{8'd0,  1'b1, 1'b0, 1'b1, 8'd0,  1'b0, 1'b0},
    '{8'd13, 1'b1, 1'b1, 1'b0, 8'd8,  1'b1, 1'b0},
    '{8'd5,  1'b1, 1'b1, 1'b1, 8'd0,  1'b0, 1'b1},
    '{8'd6,  1'b0, 1'b1, 1'b1, 8'd6,  1'b0, 1'b0},
    '{8'd11, 1'b1, 1'b1, 1'b0, 8'd11, 1'b1, 1'b0},
    '{8'd4,  1'b0, 1'b1, 1'b1, 8'd8,  1'b0, 1'b0},
    '{8'd10, 1'b1, 1'b1, 1'b1, 8'd10, 1'b1, 1'b0},
    '{8'd12, 1'b1, 1'b1, 1'b1, 8'd12, 1'b1, 1'b0},
    '{8'd8,  1'b1, 1'b0, 1'b1, 8'd8,  1'b1, 1'b0},
    '{8'd1,  1'b1, 1'b0, 1'b1, 8'd8,  1'b1, 1'b0},
    '{8'd2,  1'b1, 1'b1, 1'b1, 8'd0,  1'b0, 1'b1},
    '{8'd7,  1'b1, 1'b1, 1'b1, 8'd7,  1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs one request through the full handshake and checks every stage.
  task automatic run_req(input row_t r, input logic [31:0] err);
    @(negedge clk);
    req_valid = 1'b1; req_vector = r.vec; req_errcode = err; prot_en = r.prot;
    @(negedge clk);
    req_valid = 1'b0;
    if (r.exp_rst) begin
      chk(core_reset == 1'b1, "R4 reset pulse", 32'(core_reset), 1);
      chk(restore_ip == 1'b0, "R4 no restore", 32'(restore_ip), 0);
      @(negedge clk);
      chk(core_reset == 1'b0 && busy == 1'b0, "R4 single pulse", {busy, core_reset}, 0);
    end else begin
      chk(restore_ip && restore_sp && clear_prefix, "R5 strobes",
          {restore_ip, restore_sp, clear_prefix}, 7);
      chk(busy == 1'b1, "R1 busy after accept", 32'(busy), 1);
      chk(out_vector == r.exp_vec, r.exp_vec == 8'd8 && r.vec != 8'd8 ? "R3 escalated vector" : "R2 vector",
          32'(out_vector), 32'(r.exp_vec));
      chk(push_errcode == r.exp_push, "R9 push flag", 32'(push_errcode), 32'(r.exp_push));
      chk(out_errcode == err, "R9 error code", out_errcode, err);
      @(negedge clk);
      chk(fetch_req && !restore_ip, "R5 fetch after restore", {fetch_req, restore_ip}, 2);
      fetch_done = 1'b1; fetch_ok = r.fok;
      @(negedge clk);
      fetch_done = 1'b0; fetch_ok = 1'b0;
      if (!r.fok) begin
        chk(!busy && !deliver_req, "R6 fetch abort", {busy, deliver_req}, 0);
      end else begin
        chk(deliver_req && !fetch_req, "R7 deliver req", {deliver_req, fetch_req}, 2);
        deliver_done = 1'b1; deliver_ok = r.dok;
        @(negedge clk);
        deliver_done = 1'b0; deliver_ok = 1'b0;
        chk(!busy && !deliver_req, "R7 return idle", {busy, deliver_req}, 0);
      end
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !restore_ip && !fetch_req && !deliver_req && !core_reset && !push_errcode,
        "R11 reset state", {busy, restore_ip, fetch_req, deliver_req, core_reset, push_errcode}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (TBL[i]) run_req(TBL[i], 32'hE000_0000 | 32'(i));

    // R10: request while in fetch stage is ignored
    @(negedge clk);
    req_valid = 1'b1; req_vector = 8'd20; req_errcode = 32'h1; prot_en = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vector = 8'd21;
    fetch_done = 1'b1; fetch_ok = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; fetch_done = 1'b0; fetch_ok = 1'b0;
    // R10 collision: request in the same cycle as delivery success
    req_valid = 1'b1; req_vector = 8'd22;
    deliver_done = 1'b1; deliver_ok = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; deliver_done = 1'b0; deliver_ok = 1'b0;
    chk(!busy, "R10 colliding request dropped", 32'(busy), 0);
    chk(out_vector == 8'd20, "R10 vector untouched", 32'(out_vector), 20);
    @(negedge clk);
    chk(!busy, "R10 still idle", 32'(busy), 0);

    // R8: depth cleared, next request keeps its own vector
    run_req('{8'd19, 1'b1, 1'b1, 1'b1, 8'd19, 1'b0, 1'b0}, 32'h55);

    // R11: reset in mid flight returns to idle
    @(negedge clk);
    req_valid = 1'b1; req_vector = 8'd13;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !push_errcode && !restore_ip, "R11 mid-flight reset",
        {busy, push_errcode, restore_ip}, 0);
    rst_n = 1'b1;
    run_req('{8'd3, 1'b1, 1'b1, 1'b1, 8'd3, 1'b0, 1'b0}, 32'h77);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule